// File: doc/BRIEF.md
# Blocked Carry-Skip Fraction Adder

This block is the wide adder at the centre of a floating-point fraction datapath. It takes one operand from the fraction bus and a second operand from the B register. Each operand is 69 bits: a 64-bit significand, the guard, round and sticky positions, and headroom. The block writes a 70-bit result into a sum register, so the carry out of the top operand bit is kept as result bit 69. A subtract control turns the operation into a two's-complement subtraction. A force-zero control replaces the fraction-bus operand with zero.

Each bit position is first classed in parallel as generate, propagate or kill. The carry then moves along short local chains of four bits each. When all four positions of a group propagate, the carry entering the group goes straight to the next group. One addition takes two clock cycles. In the first cycle the operands are captured and the lower half of the groups is resolved. In the second cycle the upper groups are finished and the sum register is loaded.

A sequencer pulses `start_i` with the operands and controls. It then waits for `valid_o`. While `busy_o` is high, the adder ignores any new start request.

Top module: `frac_skip_adder`

## Requirements
- R1: After reset, `busy_o` and `valid_o` are low and `sum_o` is zero.
- R2: With `sub_i`=0 and `zero_a_i`=0, the result is the 70-bit sum `bus_a_i + breg_i`, where bit 69 is the carry out.
- R3: With `sub_i`=1, the result is `bus_a_i + ~breg_i + 1`, evaluated as a 70-bit value with both operands zero-extended from 69 bits. Bit 69 is 1 exactly when `bus_a_i >= breg_i` (no borrow).
- R4: With `zero_a_i`=1, the fraction-bus operand is treated as zero for both addition and subtraction.
- R5: A start is accepted when `start_i` is high at a rising edge while `busy_o` is low. `busy_o` is then high for exactly one cycle. After the second rising edge from acceptance, `valid_o` is high for one cycle and `sum_o` carries the result. `busy_o` and `valid_o` are never high together.
- R6: A start request at an edge where `busy_o` is high is ignored. It does not change the pending result or its timing.
- R7: `sum_o` holds its value in every cycle in which `valid_o` is low.
- R8: A carry crosses any run of groups whose positions all propagate. This includes a carry from bit 0 all the way into bit 69.
- R9: A start in the cycle in which `valid_o` is high is accepted. New operations can therefore begin every two cycles.
- R10: Operands and controls are sampled only at the accepting edge. Later changes to them do not alter the pending result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request to begin an operation |
| sub_i | input | 1 | 1 selects subtraction of the B-register operand |
| zero_a_i | input | 1 | 1 replaces the fraction-bus operand with zero |
| bus_a_i | input | 69 | Operand from the fraction bus |
| breg_i | input | 69 | Operand from the B register |
| busy_o | output | 1 | An operation is in its first cycle; starts are ignored |
| valid_o | output | 1 | One-cycle pulse: `sum_o` has just been loaded |
| sum_o | output | 70 | Sum register |

## Verification
Two events can fall on the same edge. The first is the sum register loading the completion of one operation. The second is the acceptance of the next start, which happens in the cycle where `valid_o` is high. The scoreboard provokes this by issuing back-to-back operations. It also holds `start_i` high with altered operands through the busy cycle, so that the ignored request falls on the edge between acceptance and completion. Each result is judged by popping its expected value and checking both the value and the two-cycle arrival. Any `valid_o` with no pending item, or any item left unclaimed, counts as a failure.

// File: rtl/fsa_pkg.sv
package fsa_pkg;

  typedef enum logic [1:0] {
    BC_KILL = 2'b00,
    BC_PROP = 2'b01,
    BC_GEN  = 2'b10
  } bit_class_e;

  function automatic bit_class_e classify(input logic a, input logic b);
    bit_class_e cls;
    if (a && b)       cls = BC_GEN;
    else if (a ^ b)   cls = BC_PROP;
    else              cls = BC_KILL;
    return cls;
  endfunction

endpackage

// File: rtl/fsa_classify.sv
module fsa_classify #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] gen_o,
  output logic [W-1:0] prop_o
);
  import fsa_pkg::*;

  for (genvar i = 0; i < W; i++) begin : g_bit
    bit_class_e cls;
    assign cls       = classify(a_i[i], b_i[i]);
    assign gen_o[i]  = (cls == BC_GEN);
    assign prop_o[i] = (cls == BC_PROP);
  end

endmodule

// File: rtl/fsa_group.sv
module fsa_group #(
  parameter int GW = 4
) (
  input  logic [GW-1:0] gen_i,
  input  logic [GW-1:0] prop_i,
  input  logic          cin_i,
  output logic [GW-1:0] sum_o,
  output logic          cout_o
);
  logic [GW:0] chain;
  logic        skip;

  always_comb begin
    chain[0] = cin_i;
    for (int i = 0; i < GW; i++) begin
      chain[i+1] = gen_i[i] | (prop_i[i] & chain[i]);
    end
  end

  assign sum_o  = prop_i ^ chain[GW-1:0];
  assign skip   = &prop_i;
  assign cout_o = skip ? cin_i : chain[GW];

endmodule

// File: rtl/fsa_chain.sv
module fsa_chain #(
  parameter int NG = 4,
  parameter int GW = 4
) (
  input  logic [NG*GW-1:0] a_i,
  input  logic [NG*GW-1:0] b_i,
  input  logic             cin_i,
  output logic [NG*GW-1:0] sum_o,
  output logic             cout_o
);
  localparam int W = NG * GW;

  logic [W-1:0] gen;
  logic [W-1:0] prop;
  logic [NG:0]  gcarry;

  fsa_classify #(.W(W)) u_cls (
    .a_i    (a_i),
    .b_i    (b_i),
    .gen_o  (gen),
    .prop_o (prop)
  );

  assign gcarry[0] = cin_i;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    fsa_group #(.GW(GW)) u_grp (
      .gen_i  (gen[g*GW +: GW]),
      .prop_i (prop[g*GW +: GW]),
      .cin_i  (gcarry[g]),
      .sum_o  (sum_o[g*GW +: GW]),
      .cout_o (gcarry[g+1])
    );
  end

  assign cout_o = gcarry[NG];

endmodule

// File: rtl/frac_skip_adder.sv
module frac_skip_adder #(
  parameter int OPW = 69,
  parameter int GW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic           sub_i,
  input  logic           zero_a_i,
  input  logic [OPW-1:0] bus_a_i,
  input  logic [OPW-1:0] breg_i,
  output logic           busy_o,
  output logic           valid_o,
  output logic [OPW:0]   sum_o
);
  localparam int SW   = OPW + 1;
  localparam int NGRP = (SW + GW - 1) / GW;
  localparam int PW   = NGRP * GW;
  localparam int LG   = NGRP / 2;
  localparam int UG   = NGRP - LG;
  localparam int LW   = LG * GW;
  localparam int UW   = UG * GW;

  // reset synchroniser
  logic [1:0] rst_pipe;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ns = rst_pipe[1];

  // stage 1: operand conditioning and lower groups
  logic          accept;
  logic [PW-1:0] a_eff;
  logic [PW-1:0] b_eff;
  logic [LW-1:0] lo_sum;
  logic          lo_cout;

  logic          s1_vld_q, s1_vld_d;
  logic [UW-1:0] s1_hi_a_q, s1_hi_a_d;
  logic [UW-1:0] s1_hi_b_q, s1_hi_b_d;
  logic [LW-1:0] s1_lo_q,   s1_lo_d;
  logic          s1_c_q,    s1_c_d;

  assign accept = start_i & ~s1_vld_q;

  always_comb begin
    a_eff = '0;
    b_eff = '0;
    a_eff[OPW-1:0] = zero_a_i ? '0 : bus_a_i;
    b_eff[OPW-1:0] = sub_i ? ~breg_i : breg_i;
  end

  fsa_chain #(.NG(LG), .GW(GW)) u_lo (
    .a_i    (a_eff[LW-1:0]),
    .b_i    (b_eff[LW-1:0]),
    .cin_i  (sub_i),
    .sum_o  (lo_sum),
    .cout_o (lo_cout)
  );

  always_comb begin
    s1_vld_d  = accept;
    s1_hi_a_d = s1_hi_a_q;
    s1_hi_b_d = s1_hi_b_q;
    s1_lo_d   = s1_lo_q;
    s1_c_d    = s1_c_q;
    if (accept) begin
      s1_hi_a_d = a_eff[PW-1:LW];
      s1_hi_b_d = b_eff[PW-1:LW];
      s1_lo_d   = lo_sum;
      s1_c_d    = lo_cout;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      s1_vld_q  <= 1'b0;
      s1_hi_a_q <= '0;
      s1_hi_b_q <= '0;
      s1_lo_q   <= '0;
      s1_c_q    <= 1'b0;
    end else begin
      s1_vld_q  <= s1_vld_d;
      s1_hi_a_q <= s1_hi_a_d;
      s1_hi_b_q <= s1_hi_b_d;
      s1_lo_q   <= s1_lo_d;
      s1_c_q    <= s1_c_d;
    end
  end

  // stage 2: upper groups and sum register
  logic [UW-1:0] hi_sum;
  logic          hi_cout;
  logic [PW-1:0] full_sum;
  logic [SW-1:0] sum_q, sum_d;
  logic          vld_q, vld_d;
  logic          unused_bits;

  fsa_chain #(.NG(UG), .GW(GW)) u_hi (
    .a_i    (s1_hi_a_q),
    .b_i    (s1_hi_b_q),
    .cin_i  (s1_c_q),
    .sum_o  (hi_sum),
    .cout_o (hi_cout)
  );

  assign full_sum    = {hi_sum, s1_lo_q};
  assign unused_bits = hi_cout ^ (^full_sum[PW-1:SW-1]);

  always_comb begin
    vld_d = s1_vld_q;
    sum_d = sum_q;
    if (s1_vld_q) sum_d = full_sum[SW-1:0];
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      sum_q <= '0;
      vld_q <= 1'b0;
    end else begin
      sum_q <= sum_d;
      vld_q <= vld_d;
    end
  end

  assign busy_o  = s1_vld_q;
  assign valid_o = vld_q;
  assign sum_o   = sum_q;

endmodule

// File: rtl/fsa_chk.sv
module fsa_chk #(
  parameter int OPW = 69
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start_i,
  input logic           sub_i,
  input logic           zero_a_i,
  input logic [OPW-1:0] bus_a_i,
  input logic [OPW-1:0] breg_i,
  input logic           busy_o,
  input logic           valid_o,
  input logic [OPW:0]   sum_o
);
  logic [OPW:0] ref_q;
  logic [OPW:0] ref_d;
  logic [OPW:0] opa;
  logic [OPW:0] opb;

  always_comb begin
    opa   = zero_a_i ? '0 : {1'b0, bus_a_i};
    opb   = sub_i ? {1'b0, ~breg_i} : {1'b0, breg_i};
    ref_d = opa + opb + {{OPW{1'b0}}, sub_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ref_q <= '0;
    else if (start_i && !busy_o) ref_q <= ref_d;
  end

  assert_busy_after_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  assert_valid_after_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> valid_o);

  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && valid_o));

  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> !busy_o);

  assert_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (sum_o == ref_q));   // also covers R3 and R4

  assert_sum_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(sum_o));

  assert_back_to_back_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && start_i) |=> busy_o);

endmodule

bind frac_skip_adder fsa_chk #(.OPW(OPW)) u_fsa_chk (
  .clk      (clk),
  .rst_n    (rst_ns),
  .start_i  (start_i),
  .sub_i    (sub_i),
  .zero_a_i (zero_a_i),
  .bus_a_i  (bus_a_i),
  .breg_i   (breg_i),
  .busy_o   (busy_o),
  .valid_o  (valid_o),
  .sum_o    (sum_o)
);

// File: tb/frac_skip_adder_tb_top.sv
module frac_skip_adder_tb_top;
  localparam int OPW = 69;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           start_i;
  logic           sub_i;
  logic           zero_a_i;
  logic [OPW-1:0] bus_a_i;
  logic [OPW-1:0] breg_i;
  logic           busy_o;
  logic           valid_o;
  logic [OPW:0]   sum_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [OPW:0] last_val = '0;

  logic [OPW:0] exp_q[$];
  int           cyc_q[$];
  string        tag_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  frac_skip_adder #(.OPW(OPW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sub_i(sub_i),
    .zero_a_i(zero_a_i), .bus_a_i(bus_a_i), .breg_i(breg_i),
    .busy_o(busy_o), .valid_o(valid_o), .sum_o(sum_o)
  );

  function automatic logic [OPW-1:0] rnd69();
    return {$urandom, $urandom, $urandom};
  endfunction

  task automatic check(input bit ok, input string req, input logic [OPW:0] act,
                       input logic [OPW:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: issue one operation and push its expectation
  task automatic issue(input logic [OPW-1:0] a, input logic [OPW-1:0] b,
                       input bit sub, input bit zf, input bit hold, input string tag);
    logic [OPW:0] opa, opb, e;
    while (busy_o) @(negedge clk);
    opa = zf ? '0 : {1'b0, a};
    opb = sub ? {1'b0, ~b} : {1'b0, b};
    e   = opa + opb + (sub ? 70'd1 : 70'd0);
    bus_a_i = a; breg_i = b; sub_i = sub; zero_a_i = zf; start_i = 1'b1;
    exp_q.push_back(e); cyc_q.push_back(cyc); tag_q.push_back(tag);
    @(negedge clk);
    check(busy_o && !valid_o, "R5 busy after accept", {68'd0, busy_o, valid_o}, 70'd2);
    // R6 / R10: disturb inputs during the busy cycle
    start_i  = hold;
    bus_a_i  = rnd69();
    breg_i   = rnd69();
    sub_i    = ~sub;
    zero_a_i = ~zf;
  endtask

  // monitor: compare each result against the scoreboard
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 valid with nothing pending", sum_o, '0);
      end else begin
        logic [OPW:0] e;
        int c;
        string t;
        e = exp_q.pop_front(); c = cyc_q.pop_front(); t = tag_q.pop_front();
        check(sum_o === e, t, sum_o, e);
        check(cyc - c == 2, "R5 two-cycle latency", 70'(cyc - c), 70'd2);
        last_val = sum_o;
      end
    end
  end

  initial begin
    int wd = 0;
    while (wd < 100000) begin
      @(posedge clk);
      wd++;
    end
    check(1'b0, "watchdog expired", '0, '0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; sub_i = 1'b0; zero_a_i = 1'b0;
    bus_a_i = '0; breg_i = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check(!busy_o, "R1 busy_o after reset", {69'd0, busy_o}, '0);
    check(!valid_o, "R1 valid_o after reset", {69'd0, valid_o}, '0);
    check(sum_o == '0, "R1 sum_o after reset", sum_o, '0);

    // R2 directed additions
    issue('0, '0, 1'b0, 1'b0, 1'b0, "R2 zero plus zero");
    issue(69'h0_1234_5678_9ABC_DEF0, 69'h0_0FED_CBA9_8765_4321, 1'b0, 1'b0, 1'b0, "R2 mixed add");
    // R8 carry ripples through every group into bit 69
    issue('1, 69'd1, 1'b0, 1'b0, 1'b0, "R8 all-propagate carry to bit 69");
    issue('1, '1, 1'b0, 1'b0, 1'b0, "R8 all generate");
    issue({17{4'b0101}}, {1'b1, {17{4'b1010}}}, 1'b0, 1'b0, 1'b0, "R8 skip patterns no carry");
    issue(69'h0_FFFF_FFFF_0000_000F, 69'd1, 1'b0, 1'b0, 1'b0, "R8 partial skip run");

    // R3 subtraction
    issue(69'd5, 69'd5, 1'b1, 1'b0, 1'b0, "R3 equal operands");
    issue('0, 69'd1, 1'b1, 1'b0, 1'b0, "R3 borrow zero minus one");
    issue('1, 69'd1, 1'b1, 1'b0, 1'b0, "R3 large minus one");

    // R4 force-zero
    issue('1, 69'h0_00AB_CDEF, 1'b0, 1'b1, 1'b0, "R4 force-zero add");
    issue('1, 69'h0_00AB_CDEF, 1'b1, 1'b1, 1'b0, "R4 force-zero subtract");
    issue(69'h1_2345, '0, 1'b1, 1'b1, 1'b0, "R4 force-zero minus zero");

    // R6 start held through busy cycle, R9 back-to-back
    for (int i = 0; i < 8; i++) begin
      issue(rnd69(), rnd69(), i[0], 1'b0, 1'b1, "R6 start during busy ignored");
    end
    start_i = 1'b0;

    // R10 / R9 random mix, back-to-back
    for (int i = 0; i < 60; i++) begin
      issue(rnd69(), rnd69(), $urandom_range(0, 1) == 1, $urandom_range(0, 7) == 0,
            1'b0, "R10 random operation");
    end

    // drain and check R7 hold
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R5 all results delivered", 70'(exp_q.size()), '0);
    bus_a_i = rnd69(); breg_i = rnd69();
    repeat (5) @(negedge clk);
    check(sum_o == last_val && !valid_o, "R7 sum held while idle", sum_o, last_val);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule